// File: doc/BRIEF.md
# Two-Wire Slave Register File

This block is a slave on a two-wire serial bus (clock line and open-drain data line) that exposes a flat 64-byte address space. Bytes 0 to 7 are passed through to an external clock-register port: seven timekeeping registers at 0 to 6 and a control register at 7. Bytes 8 to 63 are general-purpose storage held inside the block. A master writes by sending the device address with the write bit, then a word address, then any number of data bytes. It reads by sending the device address with the read bit, which returns bytes from the current pointer onward. A single pointer covers both regions and steps by one after every byte moved in either direction, so one sequential sweep runs through the clock registers and then the storage.

Both bus lines are oversampled by the system clock through two-flop synchronizers. The system clock must run at least eight times faster than the bus clock. The data line is driven only through an active-high pull-low enable. A power-fail input aborts whatever transfer is running, returns the pointer to zero, and makes the block deaf to the bus for as long as it stays high.

Top module: `twi_regfile_slave`

## Requirements
- R1: The block responds only to address byte 8'hD0 (write) or 8'hD1 (read), that is the 7-bit identity 7'h68 followed by the direction bit. Any other address byte gets no acknowledge, and the bytes that follow it up to the next start change nothing.
- R2: Pointer values 0 to 7 select the clock-register port: `creg_addr` equals the low three pointer bits, `creg_we` pulses for one cycle with the written byte on `creg_wdata`, and reads return `creg_rdata`. Pointer values 8 to 63 select internal storage, and writes to them leave `creg_we` low.
- R3: The pointer steps by one after every data byte written or read, and wraps from 63 to 0.
- R4: In a write, the byte after the address byte loads the pointer with its low six bits, and the upper two bits are ignored. The slave acknowledges the address byte, the word-address byte and each data byte by pulling the data line low for the ninth clock.
- R5: In a read, the slave shifts data out MSB first and changes its data-line enable only while the clock line is low. It keeps sending bytes while the master acknowledges. After a master NACK it leaves the data line released.
- R6: A data-line fall while the clock line is high is a start. It restarts address reception at any point, including in the middle of a transfer. A data-line rise while the clock line is high is a stop. It returns the slave to idle, and a partly received data byte is dropped without being written.
- R7: While `pwr_fail` is high, the slave releases the data line, holds the pointer at 0, writes nothing and acknowledges nothing. The next read after it falls starts at address 0.
- R8: After reset, `sda_oe` and `creg_we` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | High while supply is out of tolerance; aborts and blocks bus access |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High to pull the data line low |
| creg_addr | output | 3 | Clock-register index (pointer low bits) |
| creg_wdata | output | 8 | Byte written to the clock register |
| creg_we | output | 1 | One-cycle write strobe for the clock register |
| creg_rdata | input | 8 | Clock-register byte at `creg_addr` |

## Verification
Single-byte writes followed by random-access reads are run at addresses in both regions and at the region edges (0, 7, 8, 63). These separate the register-port routing from the internal storage, and show whether the strobe fires only for the low eight addresses. Multi-byte writes and reads that cross 63 to 0, followed by a read with no word address, show that a single pointer wraps and keeps counting across reads. Aborted patterns test that a frame is dropped or ignored: a foreign address, a stop after four bits, a word address with its high bits set, and power-fail in the middle of a byte. Each is followed by a read-back of the affected location.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_ACK_DEV,
    S_WADDR,
    S_ACK_WA,
    S_WDATA,
    S_ACK_WD,
    S_RDATA,
    S_RACK,
    S_RLOAD
  } twi_state_e;

  // address byte matches the 7-bit identity (bit 0 is direction)
  function automatic logic dev_match(input logic [7:0] b, input logic [6:0] id);
    return b[7:1] == id;
  endfunction

  // next byte after shifting in one serial bit
  function automatic logic [7:0] shift_in(input logic [7:0] sh, input logic b);
    return {sh[6:0], b};
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/twi_store.sv
module twi_store #(
  parameter int N  = 56,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam logic [AW-1:0] LIM = AW'(N);
  logic [7:0] mem [N];

  always_ff @(posedge clk) begin
    if (we && (waddr < LIM)) mem[waddr] <= wdata;
  end

  assign rdata = (raddr < LIM) ? mem[raddr] : 8'h00;
endmodule

// File: rtl/twi_proto.sv
module twi_proto
  import twi_pkg::*;
#(
  parameter int         AW     = 6,
  parameter logic [6:0] DEV_ID = 7'h68
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic [7:0]    rd_byte,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          rd_done,
  output logic          ev_start,
  output logic          ev_stop
);
  twi_state_e st;
  logic [7:0] sh;
  logic [2:0] cnt;
  logic       rw;
  logic       last_bit;
  logic [7:0] byte_in;

  assign ev_start = !pwr_fail && sda_fall && scl_lvl;
  assign ev_stop  = !pwr_fail && sda_rise && scl_lvl;
  assign byte_in  = shift_in(sh, sda_lvl);
  assign last_bit = scl_rise && (cnt == 3'd7);
  assign wr_en    = !pwr_fail && last_bit && (st == S_WDATA);
  assign wr_data  = byte_in;
  assign rd_done  = !pwr_fail && last_bit && (st == S_RDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; cnt <= '0; rw <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
    end else if (pwr_fail) begin
      st <= S_IDLE; cnt <= '0; ptr <= '0; sda_oe <= 1'b0;
    end else if (ev_start) begin
      st <= S_DEV; cnt <= '0; sda_oe <= 1'b0;
    end else if (ev_stop) begin
      st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_WADDR, S_WDATA: begin
          if (scl_rise) begin
            sh  <= byte_in;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (st == S_DEV) begin
                if (dev_match(byte_in, DEV_ID)) begin
                  rw <= sda_lvl;
                  st <= S_ACK_DEV;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_WADDR) begin
                ptr <= byte_in[AW-1:0];
                st  <= S_ACK_WA;
              end else begin
                ptr <= ptr + 1'b1;
                st  <= S_ACK_WD;
              end
            end
          end
        end
        S_ACK_DEV, S_ACK_WA, S_ACK_WD: begin
          if (scl_fall) begin
            if (!sda_oe) begin
              sda_oe <= 1'b1;
            end else if (st == S_ACK_DEV && rw) begin
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              st     <= S_RDATA;
            end else begin
              sda_oe <= 1'b0;
              st     <= (st == S_ACK_DEV) ? S_WADDR : S_WDATA;
            end
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
          end else if (scl_rise) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              ptr <= ptr + 1'b1;
              st  <= S_RACK;
            end
          end
        end
        S_RACK: begin
          if (scl_fall) sda_oe <= 1'b0;
          else if (scl_rise) st <= sda_lvl ? S_IDLE : S_RLOAD;
        end
        S_RLOAD: begin
          if (scl_fall) begin
            sh     <= rd_byte;
            sda_oe <= ~rd_byte[7];
            st     <= S_RDATA;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave #(
  parameter int         AW     = 6,
  parameter int         CREG_N = 8,
  parameter logic [6:0] DEV_ID = 7'h68
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_fail,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [2:0] creg_addr,
  output logic [7:0] creg_wdata,
  output logic       creg_we,
  input  logic [7:0] creg_rdata
);
  localparam int            DEPTH    = 1 << AW;
  localparam int            RAM_N    = DEPTH - CREG_N;
  localparam logic [AW-1:0] CREG_LIM = AW'(CREG_N);

  // named internal events, used by the bound checker
  logic          scl_s, sda_s, scl_rise, scl_fall, sda_rise, sda_fall;
  logic [AW-1:0] ptr, ram_idx;
  logic          wr_en, rd_done, ev_start, ev_stop, in_creg;
  logic [7:0]    wr_data, ram_q, rd_byte;

  twi_line_sync #(.STAGES(2)) u_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .lvl(scl_s), .rise(scl_rise), .fall(scl_fall));
  twi_line_sync #(.STAGES(2)) u_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .lvl(sda_s), .rise(sda_rise), .fall(sda_fall));

  twi_proto #(.AW(AW), .DEV_ID(DEV_ID)) u_proto (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .scl_lvl(scl_s), .sda_lvl(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_rise(sda_rise), .sda_fall(sda_fall), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_done(rd_done), .ev_start(ev_start), .ev_stop(ev_stop));

  assign in_creg = ptr < CREG_LIM;
  assign ram_idx = ptr - CREG_LIM;

  twi_store #(.N(RAM_N), .AW(AW)) u_store (
    .clk(clk), .we(wr_en && !in_creg), .waddr(ram_idx), .wdata(wr_data),
    .raddr(ram_idx), .rdata(ram_q));

  assign rd_byte    = in_creg ? creg_rdata : ram_q;
  assign creg_addr  = ptr[2:0];
  assign creg_wdata = wr_data;
  assign creg_we    = wr_en && in_creg;
endmodule

// File: rtl/twi_regfile_slave_chk.sv
module twi_regfile_slave_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          scl_s,
  input logic          sda_oe,
  input logic [AW-1:0] ptr,
  input logic          wr_en,
  input logic          rd_done,
  input logic          ev_start,
  input logic          ev_stop
);
  p_pf_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !sda_oe);

  p_pf_ptr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (ptr == '0));

  p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pwr_fail) |=> (ptr == AW'($past(ptr) + 1'b1)));

  p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !pwr_fail) |=> (ptr == AW'($past(ptr) + 1'b1)));

  p_oe_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(pwr_fail) && !$past(ev_start) && !$past(ev_stop))
      |-> !scl_s);
endmodule

bind twi_regfile_slave twi_regfile_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_s(scl_s), .sda_oe(sda_oe),
  .ptr(ptr), .wr_en(wr_en), .rd_done(rd_done), .ev_start(ev_start), .ev_stop(ev_stop));

// File: tb/twi_regfile_slave_tb.sv
module twi_regfile_slave_tb;
  localparam int Q = 6;
  localparam int H = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, creg_we;
  logic [2:0] creg_addr;
  logic [7:0] creg_wdata, creg_rdata;
  wire        sda_line = sda_m & ~sda_oe;

  logic [7:0] creg_mem [8];
  int         wcount = 0;
  logic [2:0] last_a;
  logic [7:0] last_d;
  int         glitch = 0;
  logic       prev_oe = 1'b0;
  int         nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  twi_regfile_slave u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .creg_addr(creg_addr), .creg_wdata(creg_wdata),
    .creg_we(creg_we), .creg_rdata(creg_rdata));

  assign creg_rdata = creg_mem[creg_addr];

  initial for (int i = 0; i < 8; i++) creg_mem[i] = 8'h40 + 8'(i);

  always @(posedge clk) begin
    if (creg_we) begin
      creg_mem[creg_addr] <= creg_wdata;
      wcount <= wcount + 1;
      last_a <= creg_addr;
      last_d <= creg_wdata;
    end
    prev_oe <= sda_oe;
    if (rst_n && !pwr_fail && (sda_oe != prev_oe) && scl_m) glitch <= glitch + 1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start;
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic b_stop;
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; w(Q); scl_m = 1'b1; w(H); scl_m = 1'b0; w(Q);
  endtask

  task automatic byte_out(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(H / 2); ack = ~sda_line; w(H / 2);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic byte_in(input logic give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(Q); scl_m = 1'b1; w(H / 2); d = {d[6:0], sda_line}; w(H / 2); scl_m = 1'b0; w(Q);
    end
    bit_out(~give_ack);
    sda_m = 1'b1;
  endtask

  task automatic wr1(input logic [7:0] wa, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    b_start; byte_out(8'hD0, a0); byte_out(wa, a1); byte_out(d, a2); b_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_at(input logic [7:0] wa, output logic [7:0] d);
    logic a;
    b_start; byte_out(8'hD0, a); byte_out(wa, a);
    b_start; byte_out(8'hD1, a); byte_in(1'b0, d); b_stop;
  endtask

  task automatic rd_cur(output logic [7:0] d, output logic ok);
    b_start; byte_out(8'hD1, ok); byte_in(1'b0, d); b_stop;
  endtask

  // {word address, data}
  localparam logic [13:0] VEC [8] = '{
    {6'd0, 8'h59}, {6'd7, 8'h93}, {6'd8, 8'hA5}, {6'd63, 8'h3C},
    {6'd30, 8'h00}, {6'd5, 8'hFF}, {6'd40, 8'h81}, {6'd9, 8'h7E}};

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic ok, a;
    logic [7:0] d;
    logic [7:0] bd [4];
    int wc;
    w(5); rst_n = 1'b1; w(3);
    chk(!sda_oe && !creg_we, "R8 reset outputs", {sda_oe, creg_we}, 0);
    rd_cur(d, ok);
    chk(ok, "R1 read address ack", ok, 1);
    chk(d == 8'h40, "R8 pointer zero after reset", d, 8'h40);

    for (int k = 0; k < 8; k++) begin
      logic [5:0] wa;
      logic [7:0] dv;
      {wa, dv} = VEC[k];
      wc = wcount;
      wr1({2'b00, wa}, dv, ok);
      chk(ok, "R4 write acks", ok, 1);
      if (wa < 6'd8) chk(wcount == wc + 1 && last_a == wa[2:0] && last_d == dv,
                         "R2 register port write", {last_a, last_d}, {wa[2:0], dv});
      else chk(wcount == wc, "R2 storage write leaves strobe low", wcount, wc);
      rd_at({2'b00, wa}, d);
      chk(d == dv, "R2 read back", d, dv);
    end

    // R4: upper bits of the word address are dropped (8'hC8 -> 8)
    wr1(8'hC8, 8'h99, ok);
    rd_at(8'd8, d);
    chk(d == 8'h99, "R4 word address high bits ignored", d, 8'h99);

    // R6: stop after four data bits drops the byte
    wr1(8'd20, 8'h55, ok);
    b_start; byte_out(8'hD0, a); byte_out(8'd20, a);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); b_stop;
    rd_at(8'd20, d);
    chk(d == 8'h55, "R6 partial byte discarded", d, 8'h55);

    // R1: foreign address gets no ack and writes nothing
    b_start; byte_out(8'hA0, a);
    chk(!a, "R1 foreign address not acked", a, 0);
    byte_out(8'd20, a); byte_out(8'h11, a); b_stop;
    rd_at(8'd20, d);
    chk(d == 8'h55, "R1 foreign frame has no effect", d, 8'h55);

    // R3: burst across 63 -> 0
    bd = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
    b_start; byte_out(8'hD0, a); byte_out(8'd62, a);
    for (int i = 0; i < 4; i++) byte_out(bd[i], a);
    b_stop;
    b_start; byte_out(8'hD0, a); byte_out(8'd62, a);
    b_start; byte_out(8'hD1, a);
    for (int i = 0; i < 4; i++) begin
      byte_in(i != 3, d);
      chk(d == bd[i], "R3 burst read across wrap", d, bd[i]);
    end
    w(2);
    chk(!sda_oe, "R5 released after NACK", sda_oe, 0);
    b_stop;
    rd_cur(d, ok);
    chk(d == 8'h42, "R3 pointer continues after burst read", d, 8'h42);

    // R7: power fail mid-byte
    wr1(8'd11, 8'h6B, ok);
    b_start; byte_out(8'hD0, a); byte_out(8'd11, a);
    bit_out(1'b0); bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
    pwr_fail = 1'b1; w(3);
    chk(!sda_oe, "R7 data line released", sda_oe, 0);
    wc = wcount;
    b_start; byte_out(8'hD0, a);
    chk(!a, "R7 no ack while power fails", a, 0);
    byte_out(8'd3, a); byte_out(8'hEE, a); b_stop;
    chk(wcount == wc, "R7 no register write while power fails", wcount, wc);
    pwr_fail = 1'b0; w(4);
    rd_cur(d, ok);
    chk(d == creg_mem[0], "R7 pointer reset to zero", d, creg_mem[0]);
    rd_at(8'd11, d);
    chk(d == 8'h6B, "R7 aborted byte not written", d, 8'h6B);

    chk(glitch == 0, "R5 enable changed while clock high", glitch, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule